// File: doc/BRIEF.md
# Paged Write Collector with Timed Commit

This block is the write side of a byte-addressed serial memory. A protocol front end hands it three kinds of events: a full starting address, a stream of data bytes, and a stop strobe. Each data byte goes into a small page buffer at the slot named by the low bits of an internal pointer. After each byte only those low bits advance, so a burst that runs past the end of a page comes back to the start of the same page and overwrites the bytes held there.

Nothing reaches the storage array while bytes are arriving. When a stop arrives and at least one byte has been taken since the last address load or commit, the block starts a programming interval of a fixed number of clocks and raises `busy`. While `busy` is high it ignores every input strobe. On the last clock of the interval it writes every received byte of the page into the array in one step. Slots that received nothing keep their old contents. A combinational read port lets the array contents be observed.

Top module: `pwb_top`

## Requirements
- R1: After reset, `busy` is low and every array location reads 0x00.
- R2: An address load sets the pointer to `addr_in` and discards every byte received since the previous load or commit. Discarded bytes are never written to the array.
- R3: Each accepted data byte is stored at the current pointer. Only the low log2(PAGE_BYTES) pointer bits (5 bits by default) then increase by one, wrapping from the last slot to slot 0. The upper bits do not change.
- R4: When more than PAGE_BYTES bytes arrive before a stop, the later bytes overwrite the earlier ones in the same slots, and the last byte written to a slot is the value committed.
- R5: The array does not change while bytes are collected, and it does not change during the programming interval until its final clock.
- R6: A stop accepted while at least one byte is pending raises `busy` on the next clock edge. `busy` then stays high for exactly PROG_CYCLES clocks.
- R7: When `busy` falls, every slot that received a byte holds its last byte at address {page, slot}. Every other address is unchanged.
- R8: A stop with no pending bytes does not raise `busy`.
- R9: While `busy` is high, the address load, data and stop strobes have no effect on the pointer, the pending bytes or the timer.
- R10: When strobes coincide, an address load wins over data and stop, and data wins over stop. The strobes that lose are ignored.
- R11: A commit clears the pending bytes but not the pointer. A stop right after a commit starts no new interval, and later bytes continue from where the pointer stood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load strobe for the starting address |
| addr_in | input | ADDR_W | Starting memory address |
| data_strobe | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte |
| stop | input | 1 | End-of-transfer strobe |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` (combinational) |
| busy | output | 1 | High during the programming interval |

## Verification
A wrong pointer, for example one that carries into the page bits or forgets its position after a commit, shows up at the read port as bytes in the wrong page or slot. This appears as soon as `busy` falls after that transfer. A pending mask that is left stale or cleared too early shows up either as a spurious or missing `busy` on the next stop, which is visible one clock later, or as old bytes committed again or fresh bytes missing from the array. A timer error shows up directly as a `busy` pulse of the wrong length, or as array contents that change before the pulse ends.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE,
        CMD_LOAD,
        CMD_DATA,
        CMD_STOP
    } pwb_cmd_e;

    // Resolve simultaneous strobes: load > data > stop; nothing while busy.
    function automatic pwb_cmd_e pwb_decode(input logic busy,
                                            input logic ld,
                                            input logic dv,
                                            input logic st);
        pwb_cmd_e c;
        c = CMD_IDLE;
        if (!busy) begin
            if (ld)      c = CMD_LOAD;
            else if (dv) c = CMD_DATA;
            else if (st) c = CMD_STOP;
        end
        return c;
    endfunction

endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_slot,
    input  logic [7:0]              wr_data,
    output logic [PAGE_BYTES*8-1:0] page_flat
);

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        logic [7:0] byte_d, byte_q;

        always_comb begin
            byte_d = byte_q;
            if (wr_en && (wr_slot == OFF_W'(s))) byte_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end

        assign page_flat[s*8 +: 8] = byte_q;
    end

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
    parameter int PROG_CYCLES = 20,
    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(PROG_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);

endmodule

// File: rtl/pwb_mem_array.sv
module pwb_mem_array #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W  = $clog2(PAGE_BYTES),
    localparam int BASE_W = ADDR_W - OFF_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [BASE_W-1:0]       base,
    input  logic [PAGE_BYTES*8-1:0] page_flat,
    input  logic [PAGE_BYTES-1:0]   mask,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [7:0]              rd_data
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
        end else if (commit) begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (mask[s]) mem_q[{base, OFF_W'(s)}] <= page_flat[s*8 +: 8];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pwb_top.sv
module pwb_top
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_strobe,
    input  logic [7:0]        data_in,
    input  logic              stop,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [ADDR_W-1:0]     ptr;
        logic [PAGE_BYTES-1:0] mask;
    } state_t;

    state_t   state_d, state_q;
    pwb_cmd_e cmd;
    logic     tmr_busy, tmr_done, prog_start, buf_we;
    logic [OFF_W-1:0]        off_q;
    logic [PAGE_BYTES*8-1:0] page_flat;
    logic [ADDR_W-1:0]       ptr_q;
    logic [PAGE_BYTES-1:0]   mask_q;

    assign off_q  = state_q.ptr[OFF_W-1:0];
    assign ptr_q  = state_q.ptr;
    assign mask_q = state_q.mask;

    always_comb begin
        state_d    = state_q;
        prog_start = 1'b0;
        buf_we     = 1'b0;
        cmd        = pwb_decode(tmr_busy, addr_load, data_strobe, stop);
        unique case (cmd)
            CMD_LOAD: begin
                state_d.ptr  = addr_in;
                state_d.mask = '0;
            end
            CMD_DATA: begin
                buf_we              = 1'b1;
                state_d.mask[off_q] = 1'b1;
                state_d.ptr         = {state_q.ptr[ADDR_W-1:OFF_W], off_q + OFF_W'(1)};
            end
            CMD_STOP: prog_start = |state_q.mask;
            default: ;
        endcase
        if (tmr_done) state_d.mask = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES)) page_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_we),
        .wr_slot  (off_q),
        .wr_data  (data_in),
        .page_flat(page_flat)
    );

    pwb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) tmr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .start(prog_start),
        .busy (tmr_busy),
        .done (tmr_done)
    );

    pwb_mem_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) mem_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (tmr_done),
        .base     (state_q.ptr[ADDR_W-1:OFF_W]),
        .page_flat(page_flat),
        .mask     (state_q.mask),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign busy = tmr_busy;

    localparam int UNUSED_BASE = BASE_W;

endmodule

// File: rtl/pwb_top_chk.sv
module pwb_top_chk #(
    parameter int ADDR_W      = 10,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 20,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int RUN_W = $clog2(PROG_CYCLES + 2) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  addr_load,
    input logic                  data_strobe,
    input logic                  stop,
    input logic                  busy,
    input logic [ADDR_W-1:0]     ptr_q,
    input logic [PAGE_BYTES-1:0] mask_q
);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == RUN_W'(PROG_CYCLES));

    // R6
    stop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop && !addr_load && !data_strobe && (mask_q != '0)) |=> busy);

    // R8
    stop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop && !addr_load && !data_strobe && (mask_q == '0)) |=> !busy);

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_q));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && data_strobe && !addr_load) |=>
            (ptr_q[OFF_W-1:0] == $past(ptr_q[OFF_W-1:0]) + OFF_W'(1)) &&
            (ptr_q[ADDR_W-1:OFF_W] == $past(ptr_q[ADDR_W-1:OFF_W])));

    // R2
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && addr_load) |=> (mask_q == '0));

endmodule

bind pwb_top pwb_top_chk #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .data_strobe(data_strobe),
    .stop(stop), .busy(busy), .ptr_q(ptr_q), .mask_q(mask_q)
);

// File: tb/pwb_top_tb_top.sv
`timescale 1ns/100ps
module pwb_top_tb_top;

    localparam int AW = 10;
    localparam int PB = 32;
    localparam int PC = 20;
    localparam int OW = $clog2(PB);
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          data_strobe = 1'b0;
    logic [7:0]    data_in = '0;
    logic          stop = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int checks = 0;
    int fails  = 0;

    logic [7:0]    ref_mem [DEPTH];
    logic [7:0]    ref_buf [PB];
    logic [PB-1:0] ref_mask;
    logic [AW-1:0] ref_ptr;

    always #10 clk = ~clk;

    pwb_top #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .data_strobe(data_strobe), .data_in(data_in), .stop(stop),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        logic [OW-1:0] o;
        o = p[OW-1:0] + OW'(1);
        return {p[AW-1:OW], o};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One-cycle strobe set; returns on the negedge after the sampling edge.
    task automatic pulse(input bit ld, input logic [AW-1:0] a, input bit dv,
                         input logic [7:0] d, input bit st);
        @(negedge clk);
        addr_load = ld; addr_in = a; data_strobe = dv; data_in = d; stop = st;
        @(negedge clk);
        addr_load = 1'b0; data_strobe = 1'b0; stop = 1'b0;
    endtask

    task automatic m_load(input logic [AW-1:0] a);
        ref_ptr = a; ref_mask = '0;
    endtask

    task automatic m_data(input logic [7:0] d);
        ref_buf[ref_ptr[OW-1:0]] = d;
        ref_mask[ref_ptr[OW-1:0]] = 1'b1;
        ref_ptr = next_ptr(ref_ptr);
    endtask

    task automatic m_commit();
        for (int s = 0; s < PB; s++)
            if (ref_mask[s]) ref_mem[{ref_ptr[AW-1:OW], OW'(s)}] = ref_buf[s];
        ref_mask = '0;
    endtask

    task automatic load(input logic [AW-1:0] a);
        pulse(1'b1, a, 1'b0, 8'h00, 1'b0); m_load(a);
    endtask

    task automatic put(input logic [7:0] d);
        pulse(1'b0, '0, 1'b1, d, 1'b0); m_data(d);
    endtask

    function automatic int read_at(input logic [AW-1:0] a);
        return 0;
    endfunction

    task automatic sweep_page(input logic [AW-OW-1:0] base, input string req);
        int bad = 0; int act = 0; int exp = 0;
        for (int s = 0; s < PB; s++) begin
            rd_addr = {base, OW'(s)}; #0.1;
            if (rd_data !== ref_mem[rd_addr]) begin
                if (bad == 0) begin act = rd_data; exp = ref_mem[rd_addr]; end
                bad++;
            end
        end
        check(bad == 0, req, act, exp);
    endtask

    task automatic sweep_all(input string req);
        int bad = 0; int act = 0; int exp = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a); #0.01;
            if (rd_data !== ref_mem[a]) begin
                if (bad == 0) begin act = rd_data; exp = ref_mem[a]; end
                bad++;
            end
        end
        check(bad == 0, req, act, exp);
    endtask

    // Stop with pending bytes: check busy onset, mid-interval array, length, commit.
    task automatic stop_commit(input logic [AW-1:0] probe);
        int n = 0;
        pulse(1'b0, '0, 1'b0, 8'h00, 1'b1);
        check(busy === 1'b1, "R6 busy after stop", busy, 1);
        rd_addr = probe; #0.1;
        check(rd_data === ref_mem[probe], "R5 array unchanged during interval", rd_data, ref_mem[probe]);
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(n == PC, "R6 busy length", n, PC);
        m_commit();
        sweep_page(ref_ptr[AW-1:OW], "R7 page contents after commit");
    endtask

    task automatic expect_idle_stop(input string req);
        pulse(1'b0, '0, 1'b0, 8'h00, 1'b1);
        check(busy === 1'b0, req, busy, 0);
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        finish_up();
    end

    initial begin
        logic [AW-1:0] a;
        logic [AW-1:0] probe;
        logic [AW-1:0] keep_ptr;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        for (int i = 0; i < PB; i++) ref_buf[i] = 8'h00;
        ref_mask = '0; ref_ptr = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1 busy low after reset", busy, 0);
        sweep_all("R1 array zero after reset");

        // R8: stop with nothing pending
        expect_idle_stop("R8 empty stop starts no interval");

        // R3: start near the page end, wrap inside the page
        a = AW'(3 * PB + 30);
        load(a);
        for (int i = 0; i < 5; i++) put(8'hA0 + 8'(i));
        stop_commit(a);
        rd_addr = AW'(3 * PB); #0.1;
        check(rd_data === 8'hA2, "R3 wrapped byte lands at slot 0", rd_data, 8'hA2);
        rd_addr = AW'(4 * PB); #0.1;
        check(rd_data === 8'h00, "R3 next page untouched", rd_data, 0);

        // R4: overflow beyond one page
        a = AW'(7 * PB + 4);
        load(a);
        for (int i = 0; i < 40; i++) put(8'(i + 1));
        stop_commit(a);
        rd_addr = AW'(7 * PB + 4); #0.1;
        check(rd_data === 8'd33, "R4 last write wins", rd_data, 33);

        // R2: reload discards pending bytes
        load(AW'(10 * PB + 1));
        put(8'h55); put(8'h66); put(8'h77);
        a = AW'(12 * PB + 8);
        load(a);
        put(8'h11); put(8'h22);
        stop_commit(a);
        sweep_page(AW'(10 * PB) >> OW, "R2 discarded page unchanged");

        // R11: stop right after commit
        expect_idle_stop("R11 stop after commit idle");
        keep_ptr = ref_ptr;
        put(8'h99);
        stop_commit(keep_ptr);
        rd_addr = keep_ptr; #0.1;
        check(rd_data === 8'h99, "R11 pointer continues after commit", rd_data, 8'h99);

        // R9: strobes during busy are ignored
        a = AW'(20 * PB);
        load(a);
        put(8'hC1);
        pulse(1'b0, '0, 1'b0, 8'h00, 1'b1);
        m_commit();
        keep_ptr = ref_ptr;
        pulse(1'b1, AW'(25 * PB), 1'b0, 8'h00, 1'b0);
        pulse(1'b0, '0, 1'b1, 8'hEE, 1'b0);
        pulse(1'b0, '0, 1'b0, 8'h00, 1'b1);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
        sweep_page(AW'(20 * PB) >> OW, "R9 commit unaffected by busy strobes");
        expect_idle_stop("R9 data during busy not pending");
        put(8'hC2);
        stop_commit(keep_ptr);
        rd_addr = keep_ptr; #0.1;
        check(rd_data === 8'hC2, "R9 load during busy ignored", rd_data, 8'hC2);
        sweep_page(AW'(25 * PB) >> OW, "R9 ignored load page untouched");

        // R10: priority among coincident strobes
        load(AW'(28 * PB + 3));
        put(8'h31);
        a = AW'(29 * PB + 0);
        pulse(1'b1, a, 1'b1, 8'h42, 1'b1);
        m_load(a);
        check(busy === 1'b0, "R10 load beats data and stop", busy, 0);
        pulse(1'b0, '0, 1'b1, 8'h43, 1'b1);
        m_data(8'h43);
        check(busy === 1'b0, "R10 data beats stop", busy, 0);
        stop_commit(a);
        sweep_page(AW'(28 * PB) >> OW, "R10 discarded byte not committed");

        // Random transfers
        for (int t = 0; t < 20; t++) begin
            a = AW'($urandom_range(0, DEPTH - 1));
            n = $urandom_range(1, 70);
            load(a);
            probe = a;
            for (int i = 0; i < n; i++) put(8'($urandom));
            stop_commit(probe);
        end

        sweep_all("R7 full array after random transfers");
        finish_up();
    end

endmodule